// File: doc/BRIEF.md
# Clock Source Select Register

An 8-bit control register that software writes to choose where the system clock and the module clock come from. It stores three select bits and turns them into two effective selections. The first is a 2-bit system-clock source code: crystal, slow clock or PLL. The second is a single flag that tells the module clock to run from the slow clock instead of the peripheral clock. The clock multiplexers, oscillator, PLL and slow-clock divider sit outside this block and consume these outputs.

The register guards against selecting a PLL that is not running. A write that sets the PLL select bit is refused while the PLL-on status input is low. If the PLL drops out while it is selected, the stored bit is cleared on the next clock edge. A limp-home input overrides the effective outputs: it forces the PLL source and the peripheral module clock. Software reads keep returning the stored bits during limp-home. Reads are combinational. A write takes effect at the clock edge that samples the write strobe.

Top module: `clk_src_sel`

## Requirements
- R1: After reset `rdata_o` reads 0x00, `sys_src_o` is 2'b00 and `mod_slow_o` is 0.
- R2: A write stores data bit 6 (PLL select), bit 5 (slow select) and bit 2 (module slow select) at the sampling edge. These bits appear at the same positions in `rdata_o`.
- R3: Bits 7, 4, 3, 1 and 0 always read as 0, whatever data was written.
- R4: A write with data bit 6 = 1 while `pll_on_i` = 0 leaves the PLL select bit at 0. The other bits of that same write are still stored.
- R5: If `pll_on_i` is 0 at a clock edge while the PLL select bit is 1, the bit is 0 after that edge.
- R6: Without limp-home, `sys_src_o` encodes the source as 2'b10 (PLL) when the PLL select bit is 1. Otherwise it is 2'b01 (slow) when the slow select bit is 1, and 2'b00 (crystal) when it is 0. The slow select bit has no effect while the PLL select bit is 1.
- R7: Without limp-home, `mod_slow_o` equals the stored module slow select bit.
- R8: While `limp_i` = 1, `sys_src_o` = 2'b10 and `mod_slow_o` = 0. `rdata_o` still returns the stored bits.
- R9: Without a write strobe, the slow and module select bits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe, sampled at the rising edge |
| wdata_i | input | 8 | Write data |
| pll_on_i | input | 1 | PLL running status |
| limp_i | input | 1 | Limp-home mode |
| rdata_o | output | 8 | Stored register value, combinational |
| sys_src_o | output | 2 | Effective system-clock source code |
| mod_slow_o | output | 1 | Effective module clock from slow clock |

## Verification
A write or a PLL drop takes effect at the rising edge that samples it, so `rdata_o` and the effective outputs are due one edge after the stimulus. The bench drives inputs on the falling edge and samples on the next falling edge, which lies half a period after the updating edge. Limp-home acts with no register in the path, so its effect is checked in the same low phase in which `limp_i` changed, before any rising edge intervenes.

// File: rtl/csel_pkg.sv
package csel_pkg;
  parameter int REG_W    = 8;
  parameter int PLL_BIT  = 6;
  parameter int SLOW_BIT = 5;
  parameter int MOD_BIT  = 2;
  parameter int SRC_W    = 2;

  typedef enum logic [SRC_W-1:0] {
    SRC_XTAL = 2'b00,
    SRC_SLOW = 2'b01,
    SRC_PLL  = 2'b10
  } sys_src_e;
endpackage

// File: rtl/csel_store.sv
module csel_store
  import csel_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             pll_on_i,
  output logic             pll_q_o,
  output logic             slow_q_o,
  output logic             mod_q_o
);
  logic pll_d, slow_d, mod_d;

  always_comb begin
    pll_d  = pll_q_o;
    slow_d = slow_q_o;
    mod_d  = mod_q_o;
    if (wr_en_i) begin
      pll_d  = wdata_i[PLL_BIT];
      slow_d = wdata_i[SLOW_BIT];
      mod_d  = wdata_i[MOD_BIT];
    end
    // PLL select may only hold 1 while PLL runs
    pll_d = pll_d & pll_on_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pll_q_o  <= 1'b0;
      slow_q_o <= 1'b0;
      mod_q_o  <= 1'b0;
    end else begin
      pll_q_o  <= pll_d;
      slow_q_o <= slow_d;
      mod_q_o  <= mod_d;
    end
  end

  p_write_slow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (slow_q_o == $past(wdata_i[SLOW_BIT])) && (mod_q_o == $past(wdata_i[MOD_BIT])));
  p_refuse_pll_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wdata_i[PLL_BIT] && !pll_on_i) |=> !pll_q_o);
  p_drop_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pll_on_i && pll_q_o) |=> !pll_q_o);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(slow_q_o) && $stable(mod_q_o));
endmodule

// File: rtl/csel_route.sv
module csel_route
  import csel_pkg::*;
(
  input  logic             pll_q_i,
  input  logic             slow_q_i,
  input  logic             mod_q_i,
  input  logic             limp_i,
  output logic [SRC_W-1:0] sys_src_o,
  output logic             mod_slow_o
);
  sys_src_e src;

  always_comb begin
    if (limp_i || pll_q_i) src = SRC_PLL;
    else if (slow_q_i)     src = SRC_SLOW;
    else                   src = SRC_XTAL;
  end

  assign sys_src_o  = src;
  assign mod_slow_o = mod_q_i & ~limp_i;

  always_comb begin
    p_code_legal_r6: assert (sys_src_o != 2'b11);
    if (limp_i) p_limp_force_r8: assert (sys_src_o == SRC_PLL && !mod_slow_o);
  end
endmodule

// File: rtl/csel_rdmux.sv
module csel_rdmux
  import csel_pkg::*;
(
  input  logic             pll_q_i,
  input  logic             slow_q_i,
  input  logic             mod_q_i,
  output logic [REG_W-1:0] rdata_o
);
  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (i == PLL_BIT)       begin : g_pll  assign rdata_o[i] = pll_q_i;  end
    else if (i == SLOW_BIT) begin : g_slow assign rdata_o[i] = slow_q_i; end
    else if (i == MOD_BIT)  begin : g_mod  assign rdata_o[i] = mod_q_i;  end
    else                    begin : g_zero assign rdata_o[i] = 1'b0;     end
  end
endmodule

// File: rtl/clk_src_sel.sv
module clk_src_sel
  import csel_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             pll_on_i,
  input  logic             limp_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [SRC_W-1:0] sys_src_o,
  output logic             mod_slow_o
);
  logic pll_q, slow_q, mod_q;

  csel_store u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wdata_i(wdata_i),
    .pll_on_i(pll_on_i), .pll_q_o(pll_q), .slow_q_o(slow_q), .mod_q_o(mod_q)
  );

  csel_route u_route (
    .pll_q_i(pll_q), .slow_q_i(slow_q), .mod_q_i(mod_q), .limp_i(limp_i),
    .sys_src_o(sys_src_o), .mod_slow_o(mod_slow_o)
  );

  csel_rdmux u_rdmux (
    .pll_q_i(pll_q), .slow_q_i(slow_q), .mod_q_i(mod_q), .rdata_o(rdata_o)
  );

  p_unused_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & 8'h9B) == 8'h00);
  p_mod_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !limp_i |-> mod_slow_o == rdata_o[MOD_BIT]);
endmodule

// File: tb/tb_clk_src_sel.sv
module tb_clk_src_sel;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic       pll_on_i = 1'b0;
  logic       limp_i = 1'b0;
  logic [7:0] rdata_o;
  logic [1:0] sys_src_o;
  logic       mod_slow_o;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  clk_src_sel dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive on negedge, the write lands at the next posedge, sample at following negedge
  task automatic wr(input logic [7:0] d);
    wr_en_i = 1'b1; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; wdata_i = 8'h00;
  endtask

  task automatic t_reset;
    chk("R1 rdata", rdata_o, 8'h00);
    chk("R1 sys_src", {6'd0, sys_src_o}, 8'h00);
    chk("R1 mod_slow", {7'd0, mod_slow_o}, 8'h00);
  endtask

  task automatic t_write_read;
    pll_on_i = 1'b1;
    wr(8'h64);
    chk("R2 rdata", rdata_o, 8'h64);
    chk("R6 pll src", {6'd0, sys_src_o}, 8'h02);
    chk("R7 mod_slow", {7'd0, mod_slow_o}, 8'h01);
    wr(8'h20);
    chk("R6 slow src", {6'd0, sys_src_o}, 8'h01);
    chk("R7 mod_slow clear", {7'd0, mod_slow_o}, 8'h00);
    wr(8'h00);
    chk("R6 xtal src", {6'd0, sys_src_o}, 8'h00);
    wr(8'h40);
    chk("R6 pll no slow", {6'd0, sys_src_o}, 8'h02);
  endtask

  task automatic t_unused;
    wr(8'hFF);
    chk("R3 unused zero", rdata_o, 8'h64);
    wr(8'h9B);
    chk("R3 only unused", rdata_o, 8'h00);
  endtask

  task automatic t_refuse;
    pll_on_i = 1'b0;
    wr(8'h64);
    chk("R4 pll refused", rdata_o, 8'h24);
    chk("R4 src slow", {6'd0, sys_src_o}, 8'h01);
  endtask

  task automatic t_drop;
    pll_on_i = 1'b1;
    wr(8'h44);
    chk("R5 pll set", rdata_o, 8'h44);
    pll_on_i = 1'b0;
    @(negedge clk_i);
    chk("R5 pll cleared", rdata_o, 8'h04);
    chk("R5 src xtal", {6'd0, sys_src_o}, 8'h00);
  endtask

  task automatic t_limp;
    pll_on_i = 1'b1;
    wr(8'h24);
    limp_i = 1'b1;
    #1;
    chk("R8 limp src", {6'd0, sys_src_o}, 8'h02);
    chk("R8 limp mod", {7'd0, mod_slow_o}, 8'h00);
    chk("R8 limp read", rdata_o, 8'h24);
    @(negedge clk_i);
    limp_i = 1'b0;
    #1;
    chk("R8 limp release", {6'd0, sys_src_o}, 8'h01);
  endtask

  task automatic t_hold;
    wdata_i = 8'h00;
    repeat (3) @(negedge clk_i);
    chk("R9 hold", rdata_o, 8'h24);
  endtask

  initial begin
    #35;
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_write_read();
    t_unused();
    t_refuse();
    t_drop();
    t_limp();
    t_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk_i);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule